// File: doc/BRIEF.md
# SPI Slave Configuration Loader

This block is the master side of a configuration link. It loads a bitstream into the configuration SRAM of a target FPGA that acts as an SPI slave. It owns four pins of the target: an active-low configuration reset, an active-low chip select, the serial clock and the serial data line. It also watches the target's configuration-done pin.

A start request launches a fixed sequence:

1. Reset and select are pulled low together for a minimum time.
2. Reset is released and the done pin is checked low.
3. Select is held for the long internal housekeeping interval, then dropped.
4. The bitstream arrives as a byte stream with valid/ready and a last-byte marker. It is shifted out in clock mode 0, most significant bit first.
5. After the last byte the done pin must read high.
6. Seven all-zero bytes (56 clocks) are sent to wake the loaded design.

Every fault leaves the sequence through an error exit. Each exit records its own code.

All delays are derived at elaboration from the system clock frequency parameter and always round up. The serial clock half-period, in system cycles, is taken from an input at start. It is refused if the resulting rate is outside the allowed range. A partial-reconfiguration request is refused without touching any pin.

Top module: `cfg_loader`

## Requirements
- R1: After reset and whenever `phase` is 0 (idle): `creset_n`=1, `cs_n`=1, `sck`=0, `mosi`=0, `busy`=0, `in_ready`=0. `phase` encodes 0 idle, 1 reset, 2 check, 3 housekeeping, 4 stream, 5 verify, 6 activate, 7 done, 8 error.
- R2: A `start` sampled in idle with `partial`=1 moves to error (phase 8) on the next cycle with `err_code`=3. No pin leaves its idle level.
- R3: A `start` sampled in idle with `partial`=0 is refused with `err_code`=4 if `sck_half` lies outside [HALF_MIN, HALF_MAX]. These bounds are the half-periods giving at most 25 MHz and at least 1 MHz (5 and 125 at 250 MHz). Otherwise phase 1 follows on the next cycle.
- R4: In phase 1, `creset_n` and `cs_n` are both low for exactly ceil(RESET_NS·CLK_HZ/1e9) cycles (250 by default).
- R5: Phase 2 lasts one cycle with reset released and select low. If `cfg_done` is high then, the block goes to error with `err_code`=1 and select released.
- R6: Phase 3 keeps `cs_n` low for ceil(HOUSE_US·CLK_HZ/1e6) cycles. `cs_n` is then high for at least one cycle in phase 4 before the first data clock.
- R7: Each byte takes 16·`sck_half` cycles. Each bit has a low half and then a high half of `sck_half` cycles each, MSB first. `mosi` changes only while `sck` is low, so the target captures on the rising edge.
- R8: `in_ready` is high only in phase 4 while the serialiser is idle and no last byte has been taken. A byte is taken when `in_valid` and `in_ready` are both high.
- R9: After the last byte is shifted, phase 5 lasts one cycle. If `cfg_done` is low, the block goes to error with `err_code`=2.
- R10: With `cfg_done` high in phase 5, phase 6 sends 7 zero bytes (56 rising `sck` edges with `mosi`=0) under select, then phase 7 follows.
- R11: `busy` is high exactly in phases 1 to 6. `ok` (phase 7) or `err` (phase 8) is high for one cycle, then the block is idle. `err_code` holds until the next accepted start, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in idle |
| partial | input | 1 | Marks the request as partial reconfiguration |
| sck_half | input | DIVW | Serial clock half-period in system cycles |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | Byte valid |
| in_last | input | 1 | Byte is the last of the bitstream |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| cfg_done | input | 1 | Target configuration-done pin |
| creset_n | output | 1 | Target configuration reset, active low |
| cs_n | output | 1 | Target chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to target |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | One-cycle success flag |
| err | output | 1 | One-cycle error flag |
| err_code | output | 3 | Last error: 0 none, 1 reset, 2 transfer, 3 unsupported, 4 clock rate |
| phase | output | 4 | Current sequence step |

## Verification
The two functions that share a cycle are the end of a byte's serialisation and the handshake or phase decision that follows it. When a byte's last high half ends, the same edge frees the serialiser. One cycle later the block either accepts the next byte, moves to verify after the last one, or loads the next activation byte. The bench provokes this with back-to-back valid bytes, with gaps between bytes, and at both clock-rate extremes. It judges it against a behavioural model that tracks byte time as a single cycle count and compares every pin on every clock.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [3:0] {
      PH_IDLE     = 4'd0,
      PH_RESET    = 4'd1,
      PH_CHECK    = 4'd2,
      PH_HOUSE    = 4'd3,
      PH_STREAM   = 4'd4,
      PH_VERIFY   = 4'd5,
      PH_ACTIVATE = 4'd6,
      PH_DONE     = 4'd7,
      PH_ERROR    = 4'd8
   } phase_e;

   typedef enum logic [2:0] {
      ER_NONE  = 3'd0,
      ER_RESET = 3'd1,
      ER_XFER  = 3'd2,
      ER_UNSUP = 3'd3,
      ER_CLOCK = 3'd4
   } err_e;

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   initial begin : prm_chk
      assert (W >= 1) else $error("timer width must be at least one bit");
   end

endmodule

// File: rtl/cfg_rate_check.sv
module cfg_rate_check #(
   parameter int unsigned CLK_HZ     = 250_000_000,
   parameter int unsigned SCK_MIN_HZ = 1_000_000,
   parameter int unsigned SCK_MAX_HZ = 25_000_000,
   parameter int unsigned DIVW       = 8
) (
   input  logic [DIVW-1:0] half,
   output logic            ok
);

   localparam longint unsigned HALF_MIN =
      (64'(CLK_HZ) + 2 * 64'(SCK_MAX_HZ) - 64'd1) / (2 * 64'(SCK_MAX_HZ));
   localparam longint unsigned HALF_MAX = 64'(CLK_HZ) / (2 * 64'(SCK_MIN_HZ));
   localparam longint unsigned HALF_TOP = (64'd1 << DIVW) - 64'd1;

   logic lo_ok;
   logic hi_ok;

   assign lo_ok = (64'(half) >= HALF_MIN);

   generate
      if (HALF_MAX >= HALF_TOP) begin : g_no_upper
         assign hi_ok = 1'b1;
      end else begin : g_upper
         assign hi_ok = (64'(half) <= HALF_MAX);
      end
   endgenerate

   assign ok = lo_ok & hi_ok;

   initial begin : prm_chk
      assert (SCK_MIN_HZ > 0 && SCK_MIN_HZ <= SCK_MAX_HZ)
         else $error("serial clock range is empty");
      assert (HALF_MIN <= HALF_MAX)
         else $error("system clock too slow for the serial clock range");
      assert (HALF_MIN <= HALF_TOP)
         else $error("DIVW too narrow for the smallest legal half-period");
   end

endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
   parameter int unsigned DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIVW-1:0] half,
   input  logic            load,
   input  logic [7:0]      data,
   output logic            active,
   output logic            sck,
   output logic            mosi
);

   localparam int unsigned BITS = 8;
   localparam int unsigned BW   = $clog2(BITS);

   logic [BITS-1:0] sh_q;
   logic [BW-1:0]   bit_q;
   logic [DIVW-1:0] div_q;
   logic            hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sh_q   <= '0;
         bit_q  <= '0;
         div_q  <= '0;
         hi_q   <= 1'b0;
      end else if (load) begin
         active <= 1'b1;
         sh_q   <= data;
         bit_q  <= BW'(BITS - 1);
         div_q  <= half - 1'b1;
         hi_q   <= 1'b0;
      end else if (active) begin
         if (div_q != '0) begin
            div_q <= div_q - 1'b1;
         end else begin
            div_q <= half - 1'b1;
            if (!hi_q) begin
               hi_q <= 1'b1;
            end else begin
               hi_q <= 1'b0;
               if (bit_q == '0) begin
                  active <= 1'b0;
               end else begin
                  bit_q <= bit_q - 1'b1;
                  sh_q  <= {sh_q[BITS-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign sck  = active & hi_q;
   assign mosi = active & sh_q[BITS-1];

   // R7
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck |=> (!sck || mosi == $past(mosi)));

   // R8
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 250_000_000,
   parameter int unsigned SCK_MIN_HZ = 1_000_000,
   parameter int unsigned SCK_MAX_HZ = 25_000_000,
   parameter int unsigned RESET_NS   = 1000,
   parameter int unsigned HOUSE_US   = 1200,
   parameter int unsigned ACT_CLOCKS = 49,
   parameter int unsigned DIVW       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            partial,
   input  logic [DIVW-1:0] sck_half,
   input  logic [7:0]      in_data,
   input  logic            in_valid,
   input  logic            in_last,
   output logic            in_ready,
   input  logic            cfg_done,
   output logic            creset_n,
   output logic            cs_n,
   output logic            sck,
   output logic            mosi,
   output logic            busy,
   output logic            ok,
   output logic            err,
   output logic [2:0]      err_code,
   output logic [3:0]      phase
);

   localparam longint unsigned RST_CYC =
      (64'(RESET_NS) * 64'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
   localparam longint unsigned HOUSE_CYC =
      (64'(HOUSE_US) * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000;
   localparam longint unsigned MAX_CYC   = (RST_CYC > HOUSE_CYC) ? RST_CYC : HOUSE_CYC;
   localparam int unsigned     TW        = $clog2(MAX_CYC + 64'd1);
   localparam int unsigned     ACT_BYTES = (ACT_CLOCKS + 7) / 8;
   localparam int unsigned     ACTW      = $clog2(ACT_BYTES + 1);

   phase_e          state_q, state_d;
   err_e            err_q, err_d;
   logic [DIVW-1:0] half_q;
   logic [ACTW-1:0] act_q;
   logic            sel_q;
   logic            last_q;
   logic            rate_ok;
   logic            t_load;
   logic [TW-1:0]   t_val;
   logic            t_zero;
   logic            sh_active;
   logic            take;
   logic            act_load;
   logic            sh_load;
   logic [7:0]      sh_data;
   logic            accept;

   cfg_rate_check #(
      .CLK_HZ     (CLK_HZ),
      .SCK_MIN_HZ (SCK_MIN_HZ),
      .SCK_MAX_HZ (SCK_MAX_HZ),
      .DIVW       (DIVW)
   ) u_rate (
      .half (sck_half),
      .ok   (rate_ok)
   );

   cfg_wait_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   assign in_ready = (state_q == PH_STREAM) && !sh_active && !last_q;
   assign take     = in_ready && in_valid;
   assign act_load = (state_q == PH_ACTIVATE) && !sh_active && (act_q != '0);
   assign sh_load  = take | act_load;
   assign sh_data  = take ? in_data : 8'h00;

   cfg_byte_shifter #(.DIVW(DIVW)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .half   (half_q),
      .load   (sh_load),
      .data   (sh_data),
      .active (sh_active),
      .sck    (sck),
      .mosi   (mosi)
   );

   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      t_load  = 1'b0;
      t_val   = '0;
      accept  = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (start) begin
               if (partial) begin
                  state_d = PH_ERROR;
                  err_d   = ER_UNSUP;
               end else if (!rate_ok) begin
                  state_d = PH_ERROR;
                  err_d   = ER_CLOCK;
               end else begin
                  state_d = PH_RESET;
                  err_d   = ER_NONE;
                  accept  = 1'b1;
                  t_load  = 1'b1;
                  t_val   = TW'(RST_CYC - 64'd1);
               end
            end
         end
         PH_RESET: if (t_zero) state_d = PH_CHECK;
         PH_CHECK: begin
            if (cfg_done) begin
               state_d = PH_ERROR;
               err_d   = ER_RESET;
            end else begin
               state_d = PH_HOUSE;
               t_load  = 1'b1;
               t_val   = TW'(HOUSE_CYC - 64'd1);
            end
         end
         PH_HOUSE:  if (t_zero) state_d = PH_STREAM;
         PH_STREAM: if (last_q && !sh_active) state_d = PH_VERIFY;
         PH_VERIFY: begin
            if (cfg_done) begin
               state_d = PH_ACTIVATE;
            end else begin
               state_d = PH_ERROR;
               err_d   = ER_XFER;
            end
         end
         PH_ACTIVATE: if (!sh_active && act_q == '0) state_d = PH_DONE;
         default:     state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         err_q   <= ER_NONE;
         half_q  <= DIVW'(1);
         act_q   <= '0;
         sel_q   <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         if (accept)
            half_q <= sck_half;
         if (state_q == PH_VERIFY)
            act_q <= ACTW'(ACT_BYTES);
         else if (act_load)
            act_q <= act_q - 1'b1;
         if (state_q != PH_STREAM) begin
            sel_q  <= 1'b0;
            last_q <= 1'b0;
         end else if (take) begin
            sel_q  <= 1'b1;
            last_q <= in_last;
         end
      end
   end

   assign creset_n = (state_q != PH_RESET);
   assign cs_n     = !((state_q == PH_RESET) || (state_q == PH_CHECK) ||
                       (state_q == PH_HOUSE) || (state_q == PH_VERIFY) ||
                       (state_q == PH_ACTIVATE) || (state_q == PH_STREAM && sel_q));
   assign busy     = (state_q != PH_IDLE) && (state_q != PH_DONE) && (state_q != PH_ERROR);
   assign ok       = (state_q == PH_DONE);
   assign err      = (state_q == PH_ERROR);
   assign err_code = err_q;
   assign phase    = state_q;

   initial begin : prm_chk
      assert (RESET_NS >= 200) else $error("reset hold shorter than 200 ns");
      assert (HOUSE_US >= 1)   else $error("housekeeping wait must be nonzero");
      assert (ACT_CLOCKS >= 1) else $error("activation clock count must be nonzero");
   end

   // R4
   reset_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !creset_n |-> !cs_n);

   // R2
   refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE && start && partial) |=>
         (state_q == PH_ERROR && err_q == ER_UNSUP && creset_n && cs_n && !sck && !mosi));

   // R3
   rate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE && start && !partial && !rate_ok) |=> (err_q == ER_CLOCK));

   // R5
   check_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_CHECK && cfg_done) |=> (state_q == PH_ERROR && err_q == ER_RESET && cs_n));

   // R6
   house_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_HOUSE && t_zero) |=> cs_n);

   // R8
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!sck && !mosi));

   // R10
   act_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_ACTIVATE) |-> !mosi);

   // R11
   flag_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok || err) |=> (!ok && !err && state_q == PH_IDLE));

endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;

   localparam int CLKHZ  = 250_000_000;
   localparam int HK_US  = 20;
   localparam int E_RST  = 250;
   localparam int E_HK   = 5000;
   localparam int E_HMIN = 5;
   localparam int E_HMAX = 125;
   localparam int E_ACT  = 7;

   localparam int P_IDLE = 0, P_RESET = 1, P_CHECK = 2, P_HOUSE = 3, P_STREAM = 4,
                  P_VERIFY = 5, P_ACT = 6, P_DONE = 7, P_ERROR = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start, partial;
   logic [7:0] sck_half;
   logic [7:0] in_data;
   logic       in_valid, in_last, cfg_done;
   logic       in_ready, creset_n, cs_n, sck, mosi, busy, ok, err;
   logic [2:0] err_code;
   logic [3:0] phase;

   always #2 clk = ~clk;

   cfg_loader #(.CLK_HZ(CLKHZ), .HOUSE_US(HK_US)) i_cfg_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .sck_half(sck_half),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .cfg_done(cfg_done), .creset_n(creset_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .busy(busy), .ok(ok), .err(err), .err_code(err_code), .phase(phase)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int       m_ph = 0, m_err = 0, m_t = 0, m_half = 1, m_bt = 0, m_act = 0;
   bit       m_shift = 0, m_sel = 0, m_last = 0;
   bit [7:0] m_byte = 0;

   always @(posedge clk) begin
      bit was;
      if (!rst_n) begin
         m_ph = P_IDLE; m_err = 0; m_shift = 0; m_sel = 0; m_last = 0; m_act = 0;
      end else begin
         was = m_shift;
         if (m_shift) begin
            m_bt++;
            if (m_bt == 16 * m_half) m_shift = 0;
         end
         case (m_ph)
            P_IDLE: if (start) begin
               if (partial) begin m_ph = P_ERROR; m_err = 3; end
               else if (sck_half < E_HMIN || sck_half > E_HMAX) begin m_ph = P_ERROR; m_err = 4; end
               else begin m_ph = P_RESET; m_err = 0; m_half = sck_half; m_t = E_RST; end
            end
            P_RESET: begin m_t--; if (m_t == 0) m_ph = P_CHECK; end
            P_CHECK: if (cfg_done) begin m_ph = P_ERROR; m_err = 1; end
                     else begin m_ph = P_HOUSE; m_t = E_HK; end
            P_HOUSE: begin
               m_t--;
               if (m_t == 0) begin m_ph = P_STREAM; m_sel = 0; m_last = 0; end
            end
            P_STREAM: if (!was) begin
               if (m_last) m_ph = P_VERIFY;
               else if (in_valid) begin
                  m_shift = 1; m_bt = 0; m_byte = in_data; m_sel = 1; m_last = in_last;
               end
            end
            P_VERIFY: if (cfg_done) begin m_ph = P_ACT; m_act = E_ACT; end
                      else begin m_ph = P_ERROR; m_err = 2; end
            P_ACT: if (!was) begin
               if (m_act > 0) begin m_shift = 1; m_bt = 0; m_byte = 8'h00; m_act--; end
               else m_ph = P_DONE;
            end
            default: m_ph = P_IDLE;
         endcase
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      bit e_sck, e_mosi, e_cs;
      if (rst_n) begin
         e_sck  = m_shift && (((m_bt / m_half) % 2) == 1);
         e_mosi = m_shift && m_byte[7 - (m_bt / (2 * m_half))];
         e_cs   = (m_ph == P_RESET || m_ph == P_CHECK || m_ph == P_HOUSE ||
                   m_ph == P_VERIFY || m_ph == P_ACT || (m_ph == P_STREAM && m_sel));
         chk("R1 phase", 32'(phase), 32'(m_ph));
         chk("R4 creset_n", 32'(creset_n), 32'(m_ph != P_RESET));
         chk("R6 cs_n", 32'(cs_n), 32'(!e_cs));
         chk("R7 sck", 32'(sck), 32'(e_sck));
         chk("R7 mosi", 32'(mosi), 32'(e_mosi));
         chk("R8 in_ready", 32'(in_ready), 32'(m_ph == P_STREAM && !m_shift && !m_last));
         chk("R11 busy", 32'(busy), 32'(m_ph >= P_RESET && m_ph <= P_ACT));
         chk("R11 ok", 32'(ok), 32'(m_ph == P_DONE));
         chk("R11 err", 32'(err), 32'(m_ph == P_ERROR));
         chk("R2 err_code", 32'(err_code), 32'(m_err));
      end
   end

   // target-side observers
   int       rst_cnt = 0, hk_cnt = 0, ok_cnt = 0, act_edges = 0, nbit = 0;
   bit [7:0] rx_sh = 0;
   bit [7:0] rx_q[$];
   bit [7:0] tx_q[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (phase == 4'(P_RESET)) rst_cnt++;
         if (phase == 4'(P_HOUSE)) hk_cnt++;
         if (ok) ok_cnt++;
      end
   end

   always @(posedge sck) begin
      if (!cs_n) begin
         rx_sh = {rx_sh[6:0], mosi};
         nbit++;
         if (nbit == 8) begin rx_q.push_back(rx_sh); nbit = 0; end
         if (phase == 4'(P_ACT)) act_edges++;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<=190000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic pulse_start(input int half, input bit part);
      @(posedge clk); #1;
      start = 1'b1; partial = part; sck_half = 8'(half);
      @(posedge clk); #1;
      start = 1'b0; partial = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (phase != 4'(P_IDLE));
   endtask

   task automatic send_byte(input bit [7:0] b, input bit lst);
      bit tk;
      @(posedge clk); #1;
      in_data = b; in_valid = 1'b1; in_last = lst;
      do begin
         @(negedge clk); tk = in_ready;
         @(posedge clk);
      end while (!tk);
      #1;
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic clear_obs();
      rx_q.delete(); nbit = 0; act_edges = 0; rst_cnt = 0; hk_cnt = 0; ok_cnt = 0;
   endtask

   task automatic run_load(input int half, input int gap, input bit good);
      clear_obs();
      pulse_start(half, 1'b0);
      for (int i = 0; i < tx_q.size(); i++) begin
         send_byte(tx_q[i], i == tx_q.size() - 1);
         if (i == tx_q.size() - 1 && good) cfg_done = 1'b1;
         repeat (gap) @(posedge clk);
      end
      wait_idle();
      cfg_done = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; partial = 1'b0; sck_half = 8'd5;
      in_data = 8'h00; in_valid = 1'b0; in_last = 1'b0; cfg_done = 1'b0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset creset_n", 32'(creset_n), 32'd1);
      chk("R1 reset cs_n", 32'(cs_n), 32'd1);
      chk("R1 reset sck/mosi", 32'({sck, mosi}), 32'd0);
      chk("R1 reset busy/ready", 32'({busy, in_ready}), 32'd0);

      // R2 partial refusal
      pulse_start(10, 1'b1);
      @(negedge clk);
      chk("R2 refused phase", 32'(phase), 32'(P_ERROR));
      chk("R2 refused code", 32'(err_code), 32'd3);
      chk("R2 pins quiet", 32'({creset_n, cs_n, sck, mosi}), 32'b1100);
      wait_idle();

      // R3 divider just outside both bounds
      pulse_start(E_HMIN - 1, 1'b0);
      @(negedge clk);
      chk("R3 too fast code", 32'(err_code), 32'd4);
      wait_idle();
      pulse_start(E_HMAX + 1, 1'b0);
      @(negedge clk);
      chk("R3 too slow code", 32'(err_code), 32'd4);
      wait_idle();

      // R5 done stuck high after reset; lower bound accepted (R3)
      clear_obs();
      cfg_done = 1'b1;
      pulse_start(E_HMIN, 1'b0);
      @(negedge clk);
      chk("R3 lower bound accepted", 32'(phase), 32'(P_RESET));
      wait_idle();
      chk("R5 reset failure code", 32'(err_code), 32'd1);
      chk("R4 reset length", 32'(rst_cnt), 32'(E_RST));
      chk("R6 no housekeeping after failure", 32'(hk_cnt), 32'd0);
      cfg_done = 1'b0;

      // R7 R8 R10 success, fastest clock, back-to-back bytes
      tx_q = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81};
      run_load(E_HMIN, 0, 1'b1);
      chk("R4 reset length", 32'(rst_cnt), 32'(E_RST));
      chk("R6 housekeeping length", 32'(hk_cnt), 32'(E_HK));
      chk("R7 received count", 32'(rx_q.size()), 32'(tx_q.size() + E_ACT));
      for (int i = 0; i < tx_q.size() && i < rx_q.size(); i++)
         chk("R7 received byte", 32'(rx_q[i]), 32'(tx_q[i]));
      for (int i = tx_q.size(); i < rx_q.size(); i++)
         chk("R10 activation byte", 32'(rx_q[i]), 32'd0);
      chk("R10 activation edges", 32'(act_edges), 32'(8 * E_ACT));
      chk("R11 ok pulses", 32'(ok_cnt), 32'd1);
      chk("R11 code cleared", 32'(err_code), 32'd0);

      // R7 R8 upper bound, gaps between bytes
      tx_q = '{8'h5A, 8'hC3};
      run_load(E_HMAX, 3, 1'b1);
      chk("R7 slow received count", 32'(rx_q.size()), 32'(tx_q.size() + E_ACT));
      if (rx_q.size() >= 2) begin
         chk("R7 slow byte0", 32'(rx_q[0]), 32'h5A);
         chk("R7 slow byte1", 32'(rx_q[1]), 32'hC3);
      end
      chk("R10 slow activation edges", 32'(act_edges), 32'(8 * E_ACT));
      chk("R11 slow ok pulses", 32'(ok_cnt), 32'd1);

      // R9 done never rises
      tx_q = '{8'h12, 8'h34};
      run_load(7, 1, 1'b0);
      chk("R9 transfer failure code", 32'(err_code), 32'd2);
      chk("R9 no activation", 32'(act_edges), 32'd0);
      chk("R9 bytes sent", 32'(rx_q.size()), 32'd2);
      chk("R11 no ok on failure", 32'(ok_cnt), 32'd0);

      repeat (4) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule